// File: doc/BRIEF.md
# Tuner Synthesizer Serial Control Port

This block is an I2C target that sets up the frequency synthesizer of a tuner and reports the synthesizer's state. It samples SCL and SDA with the system clock. It detects START and STOP conditions and bit edges, and it controls SDA only through an open-drain enable. A write transfer carries an address byte and then any number of two-byte groups. The top bit of the first byte in each group decides what the group loads: either the 15-bit programmable divider word, or the control settings (reference divider select, charge-pump current code, test-mode bits and an output port bit).

The divider word is built in a holding register and reaches the output in one step. That step happens when the low byte completes the 15 bits, or at a STOP that follows a lone high byte. This keeps a fine-tuning step from ever showing a half-updated ratio. A read transfer returns a status byte carrying a power-on flag and the synthesizer's lock input. The status byte is repeated for as long as the controller acknowledges.

The address is a fixed five-bit prefix followed by a two-bit select input, so up to four of these blocks can share one bus.

Top module: `tuner_synth_i2c`

## Requirements
- R1: The 7-bit target address is {5'b11000, addr_sel_i}. On a match, sda_oe_o is asserted for the acknowledge clock after the address byte. On a mismatch there is no acknowledge, and the data bytes that follow change no output.
- R2: In write mode (address byte bit 0 = 0) every received data byte is acknowledged by asserting sda_oe_o during its ninth SCL pulse.
- R3: A first byte with bit 7 = 0 supplies divider bits 14..8 from its bits 6..0. The following byte supplies bits 7..0. div_word_o keeps its old value until that second byte completes, and then takes all 15 bits at once.
- R4: A first byte with bit 7 = 1 sets cp_cur_o from bits 6..5 (00 lowest current, 11 highest) and ref_sel_o from bits 4..2. The following byte sets test_mode_o from bits 7..5 and port_o from bit 0. Each field updates when its byte completes.
- R5: Further byte groups may follow without a new address. Each group is classified again by bit 7 of its first byte, and a START restarts the classification.
- R6: A STOP that arrives after only the high divider byte moves the held bits 14..8 to div_word_o and keeps bits 7..0.
- R7: A STOP inside a byte discards the partial byte. Bytes completed before it keep their effect.
- R8: In read mode (address byte bit 0 = 1) the block sends the status byte MSB first: bit 7 = power-on flag, bit 6 = lock_i, bits 5..0 = 0. It sends the byte again after each controller acknowledge.
- R9: When the controller does not acknowledge a status byte, the block releases SDA and drives nothing more until the next START.
- R10: The power-on flag is 1 after reset. It is cleared by a STOP that ends a read transfer, and it is not cleared by the STOP of a write transfer.
- R11: During reset all register outputs are 0 and sda_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_sel_i | input | 2 | Low two bits of the target address |
| lock_i | input | 1 | Lock indication from the synthesizer |
| div_word_o | output | 15 | Programmable divider ratio |
| ref_sel_o | output | 3 | Reference divider select |
| cp_cur_o | output | 2 | Charge-pump current code |
| test_mode_o | output | 3 | Test-mode bits |
| port_o | output | 1 | Output port bit |

## Verification
Every register output changes on the third rising clock edge after the SCL or SDA edge that completes it. Two of those stages are the synchronizer and the third is the event register. The reference model in the bench therefore applies each expected change exactly three clock edges after it drives that bus edge. It compares all register outputs a quarter period after every rising edge. The acknowledge and status bits from the block move sda_oe_o three edges after an SCL fall, so the bench samples SDA only after several more cycles of SCL low plus half of the SCL high time.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;

  localparam int BYTE_W   = 8;
  localparam int CP_W     = 2;
  localparam int REF_W    = 3;
  localparam int TM_W     = 3;
  localparam int CP_HI    = 6;
  localparam int REF_HI   = 4;
  localparam int TM_HI    = 7;
  localparam int PORT_BIT = 0;
  localparam int KIND_BIT = 7;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_sh, sda_sh;
  logic          scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[LAST-1:0], scl_i};
      sda_sh <= {sda_sh[LAST-1:0], sda_i};
      scl_q  <= scl_sh[LAST];
      sda_q  <= sda_sh[LAST];
    end
  end

  assign scl_o      = scl_sh[LAST];
  assign sda_o      = sda_sh[LAST];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // data line moves while clock stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import synth_i2c_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int SEL_W  = 2,
  parameter logic [ADDR_W-SEL_W-1:0] ADDR_PREFIX = 5'b11000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  scl_rise_i,
  input  logic                  scl_fall_i,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic [SEL_W-1:0]      addr_sel_i,
  input  logic                  lock_i,
  output logic                  sda_oe_o,
  output logic                  wr_valid_o,
  output logic [BYTE_W-1:0]     wr_byte_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  tgt_state_e          state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [BYTE_W-1:0]   sh_q;
  logic                oe_q, rd_txn_q, por_q, ack_ok_q;
  logic [BYTE_W-1:0]   status;
  logic                addr_hit;

  assign status   = {por_q, lock_i, {(BYTE_W-2){1'b0}}};
  assign addr_hit = (sh_q[BYTE_W-1:1] == {ADDR_PREFIX, addr_sel_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      oe_q     <= 1'b0;
      rd_txn_q <= 1'b0;
      por_q    <= 1'b1;
      ack_ok_q <= 1'b0;
    end else if (start_i) begin
      state_q  <= ST_ADDR;
      cnt_q    <= '0;
      oe_q     <= 1'b0;
      rd_txn_q <= 1'b0;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
      oe_q     <= 1'b0;
      rd_txn_q <= 1'b0;
      if (rd_txn_q) por_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise_i && cnt_q != FULL) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end
          if (scl_fall_i && cnt_q == FULL) begin
            if (state_q == ST_WR) begin
              state_q <= ST_WR_ACK;
              oe_q    <= 1'b1;
            end else if (addr_hit) begin
              state_q  <= ST_ADDR_ACK;
              oe_q     <= 1'b1;
              rd_txn_q <= sh_q[0];
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            cnt_q <= '0;
            if (rd_txn_q) begin
              state_q <= ST_RD;
              sh_q    <= status;
              oe_q    <= ~status[BYTE_W-1];
            end else begin
              state_q <= ST_WR;
              oe_q    <= 1'b0;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall_i) begin
            state_q <= ST_WR;
            oe_q    <= 1'b0;
            cnt_q   <= '0;
          end
        end
        ST_RD: begin
          if (scl_fall_i) begin
            if (cnt_q == LAST) begin
              state_q <= ST_RD_ACK;
              oe_q    <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
              oe_q  <= ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) ack_ok_q <= ~sda_i;
          if (scl_fall_i) begin
            if (ack_ok_q) begin
              state_q <= ST_RD;
              cnt_q   <= '0;
              sh_q    <= status;
              oe_q    <= ~status[BYTE_W-1];
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o   = oe_q;
  assign wr_valid_o = (state_q == ST_WR) && scl_rise_i && (cnt_q == LAST);
  assign wr_byte_o  = {sh_q[BYTE_W-2:0], sda_i};

  // R2: acknowledge slot follows every complete data byte
  a_r2_ack_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR && scl_fall_i && cnt_q == FULL && !start_i && !stop_i)
      |=> (sda_oe_o && state_q == ST_WR_ACK));

  // R8: data line is only moved while the bus clock is low
  a_r8_hold_sda_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && !start_i && !stop_i) |=> $stable(sda_oe_o));

  // R9: missing controller acknowledge releases the line
  a_r9_release_on_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_ACK && scl_fall_i && !ack_ok_q && !start_i && !stop_i)
      |=> (state_q == ST_IDLE && !sda_oe_o));

  // R10: power-on flag is only ever cleared, and a read STOP clears it
  a_r10_por_never_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(por_q));
  a_r10_por_clear_read_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i && rd_txn_q) |=> !por_q);
endmodule

// File: rtl/synth_reg_file.sv
module synth_reg_file
  import synth_i2c_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_valid_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  output logic [DIV_W-1:0]  div_word_o,
  output logic [REF_W-1:0]  ref_sel_o,
  output logic [CP_W-1:0]   cp_cur_o,
  output logic [TM_W-1:0]   test_mode_o,
  output logic              port_o
);
  localparam int LO_W = BYTE_W;
  localparam int HI_W = DIV_W - LO_W;

  logic            second_q, ctl_q, pend_q;
  logic [HI_W-1:0] hi_q;
  logic            unused_bits;

  assign unused_bits = ^{wr_byte_i[1:0], wr_byte_i[4:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      second_q    <= 1'b0;
      ctl_q       <= 1'b0;
      pend_q      <= 1'b0;
      hi_q        <= '0;
      div_word_o  <= '0;
      ref_sel_o   <= '0;
      cp_cur_o    <= '0;
      test_mode_o <= '0;
      port_o      <= 1'b0;
    end else begin
      if (start_i) second_q <= 1'b0;
      if (wr_valid_i) begin
        if (!second_q) begin
          second_q <= 1'b1;
          ctl_q    <= wr_byte_i[KIND_BIT];
          if (wr_byte_i[KIND_BIT]) begin
            cp_cur_o  <= wr_byte_i[CP_HI -: CP_W];
            ref_sel_o <= wr_byte_i[REF_HI -: REF_W];
          end else begin
            hi_q   <= wr_byte_i[HI_W-1:0];
            pend_q <= 1'b1;
          end
        end else begin
          second_q <= 1'b0;
          if (ctl_q) begin
            test_mode_o <= wr_byte_i[TM_HI -: TM_W];
            port_o      <= wr_byte_i[PORT_BIT];
          end else begin
            div_word_o <= {hi_q, wr_byte_i};
            pend_q     <= 1'b0;
          end
        end
      end
      // lone high byte is committed at STOP
      if (stop_i && pend_q) begin
        div_word_o <= {hi_q, div_word_o[LO_W-1:0]};
        pend_q     <= 1'b0;
      end
    end
  end

  // R3: divider output frozen while the high byte waits
  a_r3_div_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !wr_valid_i && !stop_i) |=> $stable(div_word_o));

  // R6: STOP always drains the held high byte
  a_r6_stop_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && pend_q) |=> !pend_q);

  // R5: each accepted byte advances the group position
  a_r5_pair_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !start_i) |=> (second_q != $past(second_q)));
endmodule

// File: rtl/tuner_synth_i2c.sv
module tuner_synth_i2c
  import synth_i2c_pkg::*;
#(
  parameter int DIV_W       = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [1:0]       addr_sel_i,
  input  logic             lock_i,
  output logic [DIV_W-1:0] div_word_o,
  output logic [REF_W-1:0] ref_sel_o,
  output logic [CP_W-1:0]  cp_cur_o,
  output logic [TM_W-1:0]  test_mode_o,
  output logic             port_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic wr_valid;
  logic [BYTE_W-1:0] wr_byte;

  i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  i2c_tgt_engine u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .addr_sel_i (addr_sel_i),
    .lock_i     (lock_i),
    .sda_oe_o   (sda_oe_o),
    .wr_valid_o (wr_valid),
    .wr_byte_o  (wr_byte)
  );

  synth_reg_file #(.DIV_W(DIV_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_c),
    .stop_i      (stop_c),
    .wr_valid_i  (wr_valid),
    .wr_byte_i   (wr_byte),
    .div_word_o  (div_word_o),
    .ref_sel_o   (ref_sel_o),
    .cp_cur_o    (cp_cur_o),
    .test_mode_o (test_mode_o),
    .port_o      (port_o)
  );
endmodule

// File: tb/tuner_synth_i2c_tb.sv
module tuner_synth_i2c_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda_drv = 1'b1, lock = 1'b0;
  logic [1:0] sel = 2'b10;
  logic       sda_oe;
  logic [14:0] div_w;
  logic [2:0] ref_s, tm;
  logic [1:0] cp;
  logic       p0;
  wire        sda_bus = sda_drv & ~sda_oe;

  tuner_synth_i2c u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .addr_sel_i(sel), .lock_i(lock),
    .div_word_o(div_w), .ref_sel_o(ref_s), .cp_cur_o(cp),
    .test_mode_o(tm), .port_o(p0)
  );

  int n_tests = 0, n_fail = 0;
  bit cmp_en = 0;

  // behavioural model state
  int m_div = 0, m_ref = 0, m_cp = 0, m_tm = 0, m_p0 = 0, m_hi = 0;
  bit m_second = 0, m_ctl = 0, m_pend = 0, m_por = 1, m_rd = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (cmp_en) begin
      #5;
      chk("R3 div_word per clock", int'(div_w), m_div);
      chk("R4 ref_sel per clock", int'(ref_s), m_ref);
      chk("R4 cp_cur per clock", int'(cp), m_cp);
      chk("R4 test_mode per clock", int'(tm), m_tm);
      chk("R4 port per clock", int'(p0), m_p0);
    end
  end

  function automatic void model_byte(input logic [7:0] b);
    if (!m_second) begin
      m_ctl = b[7];
      if (b[7]) begin m_cp = int'(b[6:5]); m_ref = int'(b[4:2]); end
      else begin m_hi = int'(b[6:0]); m_pend = 1; end
      m_second = 1;
    end else begin
      if (m_ctl) begin m_tm = int'(b[7:5]); m_p0 = int'(b[0]); end
      else begin m_div = (m_hi << 8) | int'(b); m_pend = 0; end
      m_second = 0;
    end
  endfunction

  task automatic do_start();
    @(negedge clk) sda_drv = 1'b1;
    repeat (2) @(negedge clk); scl = 1'b1;
    repeat (4) @(negedge clk); sda_drv = 1'b0;
    repeat (3) @(posedge clk);
    m_second = 0; m_rd = 0;
    repeat (4) @(negedge clk); scl = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) sda_drv = 1'b0;
    repeat (3) @(negedge clk); scl = 1'b1;
    repeat (4) @(negedge clk); sda_drv = 1'b1;
    repeat (3) @(posedge clk);
    if (m_pend) begin m_div = (m_hi << 8) | (m_div & 8'hFF); m_pend = 0; end
    if (m_rd) m_por = 0;
    m_rd = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit model_it);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk) sda_drv = b[i];
      repeat (3) @(negedge clk); scl = 1'b1;
      repeat (3) @(posedge clk);
      if (i == 0 && model_it) model_byte(b);
      repeat (4) @(negedge clk); scl = 1'b0;
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit model_it, output logic ack);
    send_bits(b, 8, model_it);
    @(negedge clk) sda_drv = 1'b1;
    repeat (5) @(negedge clk); scl = 1'b1;
    repeat (4) @(negedge clk); ack = ~sda_bus;
    repeat (3) @(negedge clk); scl = 1'b0;
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) sda_drv = 1'b1;
      repeat (4) @(negedge clk); scl = 1'b1;
      repeat (4) @(negedge clk); d[i] = sda_bus;
      repeat (3) @(negedge clk); scl = 1'b0;
    end
    @(negedge clk) sda_drv = ~give_ack;
    repeat (4) @(negedge clk); scl = 1'b1;
    repeat (6) @(negedge clk); scl = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R11 reset div", int'(div_w), 0);
    chk("R11 reset ctl", int'({ref_s, cp, tm, p0}), 0);
    chk("R11 reset sda_oe", int'(sda_oe), 0);
    rst_n = 1'b1; cmp_en = 1;
    repeat (4) @(negedge clk);

    // R1 R2 R3 R4 R5: several groups in one transfer
    do_start();
    wr_byte(8'hC4, 0, ack); chk("R1 address ack", int'(ack), 1);
    wr_byte(8'h35, 1, ack); chk("R2 data ack", int'(ack), 1);
    chk("R3 div held after high byte", int'(div_w), 0);
    wr_byte(8'hA7, 1, ack); chk("R2 data ack", int'(ack), 1);
    chk("R3 div committed", int'(div_w), 15'h35A7);
    wr_byte(8'hD5, 1, ack);
    chk("R4 cp_cur", int'(cp), 2); chk("R4 ref_sel", int'(ref_s), 5);
    wr_byte(8'hA1, 1, ack);
    chk("R4 test_mode", int'(tm), 5); chk("R4 port", int'(p0), 1);
    wr_byte(8'h12, 1, ack); wr_byte(8'h34, 1, ack);
    chk("R5 second divider group", int'(div_w), 15'h1234);
    do_stop();

    // R6: lone high byte then STOP
    do_start();
    wr_byte(8'hC4, 0, ack); wr_byte(8'h4F, 1, ack);
    chk("R6 before STOP", int'(div_w), 15'h1234);
    do_stop();
    chk("R6 after STOP", int'(div_w), 15'h4F34);

    // R7: STOP inside a byte
    do_start();
    wr_byte(8'hC4, 0, ack); wr_byte(8'h0A, 1, ack);
    send_bits(8'hFF, 3, 0);
    do_stop();
    chk("R7 partial low byte dropped", int'(div_w), 15'h0A34);
    do_start();
    wr_byte(8'hC4, 0, ack);
    send_bits(8'hE3, 5, 0);
    do_stop();
    chk("R7 partial control byte dropped", int'({cp, ref_s}), {2'd2, 3'd5});

    // R1: foreign address ignored
    do_start();
    wr_byte(8'hC0, 0, ack); chk("R1 mismatch no ack", int'(ack), 0);
    wr_byte(8'h7F, 0, ack); chk("R1 data after mismatch no ack", int'(ack), 0);
    wr_byte(8'hFF, 0, ack);
    do_stop();
    chk("R1 outputs untouched", int'(div_w), 15'h0A34);

    // R1 other select, R5 control group after restart
    sel = 2'b01;
    do_start();
    wr_byte(8'hC2, 0, ack); chk("R1 select 01 ack", int'(ack), 1);
    wr_byte(8'h80, 1, ack); wr_byte(8'h00, 1, ack);
    do_stop();
    chk("R5 control cleared", int'({cp, ref_s, tm, p0}), 0);

    // R8 R9 R10: reads
    lock = 1'b1;
    do_start();
    wr_byte(8'hC3, 0, ack); m_rd = 1;
    chk("R8 read address ack", int'(ack), 1);
    rd_byte(1, d); chk("R10 por survives write STOP", int'(d), 8'hC0);
    rd_byte(0, d); chk("R8 status resent", int'(d), 8'hC0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) sda_drv = 1'b1;
      repeat (4) @(negedge clk); scl = 1'b1;
      repeat (4) @(negedge clk); chk("R9 released after nack", int'(sda_bus), 1);
      repeat (3) @(negedge clk); scl = 1'b0;
    end
    do_stop();

    lock = 1'b0;
    do_start();
    wr_byte(8'hC3, 0, ack); m_rd = 1;
    rd_byte(0, d); chk("R10 por cleared by read STOP", int'(d), 8'h00);
    do_stop();

    lock = 1'b1;
    do_start();
    wr_byte(8'hC3, 0, ack); m_rd = 1;
    rd_byte(0, d); chk("R8 lock bit", int'(d), 8'h40);
    do_stop();

    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule